// File: doc/BRIEF.md
# Interrupt Flag Controller

This block collects five interrupt events into one interrupt request line for a small processor. Two of the events come from neighbouring logic as single-cycle pulses: a USB transfer-complete strobe and a timer underflow strobe. The other three come from raw pin levels. Any falling edge on one of the eight port-3 pins is one event, and each of two dedicated external pins gives its own event. A pin takes part only while its direction control marks it as an input. Every pin is passed through a two-flop synchroniser before its falling edge is detected.

Each event sets a sticky pending flag. Software reads the flags from a read-only status register, picks which flags may raise the interrupt through a read/write enable register, and drops flags by writing ones to a write-only clear register. All three registers share one bit layout. The request output is a registered OR of the pending flags that are enabled.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the enable register and the status register read 0x00 and `irq_o` is low.
- R2: The enable register sits at offset 0xC1 and can be read and written. Only bits 1 to 5 are stored, so writing 0xFF reads back as 0x3E. Bits 0, 6 and 7 of every register read as 0.
- R3: A high `usb_done_i` sampled at a rising clock edge sets status bit 1 at that same edge. A high `tmr_uflow_i` sets status bit 2 in the same way. A set flag stays set until it is cleared.
- R4: A falling edge on `ext_pin_i[0]` sets status bit 4, and a falling edge on `ext_pin_i[1]` sets status bit 5. If the pin goes low before rising clock edge k, the flag is still clear after edge k+1 and is set after edge k+2. Rising edges and steady levels set nothing.
- R5: A falling edge on any of the eight `p3_pin_i` bits sets status bit 3, with the same latency as R4.
- R6: A pin whose mode bit (`p3_in_mode_i` or `ext_in_mode_i`) is 0 produces no event. A mode bit of 1 means input mode.
- R7: A flag latches even when its enable bit is 0. In that case `irq_o` stays low.
- R8: After every rising edge, `irq_o` equals the OR over all bits of (status AND enable) as it stood before that edge. So `irq_o` follows a flag or an enable change one cycle later.
- R9: Writing to the clear register at offset 0xC3 clears every status bit that is 1 in the written data. Bits written as 0 are left unchanged. The status register is at offset 0xC2.
- R10: If a new event and a clear write for the same bit arrive in the same cycle, the flag stays set.
- R11: Writes to the status register or to unmapped offsets change nothing. Reads of the clear register and of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| usb_done_i | input | 1 | USB transfer-complete pulse |
| tmr_uflow_i | input | 1 | Timer underflow pulse |
| p3_pin_i | input | 8 | Port-3 pin levels (asynchronous) |
| p3_in_mode_i | input | 8 | Port-3 direction, 1 = input |
| ext_pin_i | input | 2 | Dedicated external interrupt pin levels (asynchronous) |
| ext_in_mode_i | input | 2 | External pin direction, 1 = input |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench applies single-cycle pulses on the two strobe inputs and checks their flags at the edge that samples them. It then checks that the request follows exactly one cycle later, which separates a registered output from a combinational one. Falling edges are driven on port-3 bits 0, 3 and 7 and on both external pins, and each flag is sampled one cycle before and one cycle after its expected set edge. This catches any error in synchroniser depth, and the later rising edges show that only falling transitions are detected. The bench also runs with masked flags, with pins in output mode, with a clear write that carries zeros, and with a clear write that collides with a fresh event. Each of these separates the latching, mode gating, per-bit clearing and set-over-clear priority from the plain set path.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;
  typedef logic [REG_W-1:0] reg_t;

  // Bit positions shared by the enable, status and clear registers
  localparam int BIT_USB = 1;
  localparam int BIT_TMR = 2;
  localparam int BIT_P3  = 3;
  localparam int BIT_X0  = 4;
  localparam int BIT_X1  = 5;

  localparam reg_t FLAG_MASK = reg_t'((1 << BIT_USB) | (1 << BIT_TMR) | (1 << BIT_P3) |
                                      (1 << BIT_X0) | (1 << BIT_X1));
endpackage

// File: rtl/irq_pin_fall.sv
// Two-flop synchroniser plus falling-edge detect, one lane per pin.
module irq_pin_fall #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] mode_i,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic meta_q, sync_q, hist_q;
    logic meta_d, sync_d, hist_d;

    always_comb begin
      meta_d = pin_i[i];
      sync_d = meta_q;
      hist_d = sync_q;
    end

    // Reset to 0: a pin held high or low through reset gives no false fall.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        sync_q <= sync_d;
        hist_q <= hist_d;
      end
    end

    assign fall_o[i] = hist_q & ~sync_q & mode_i[i];
  end
endmodule

// File: rtl/irq_flag_bank.sv
// Sticky pending flags; a set in the same cycle outranks a clear.
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  reg_t set_i,
  input  reg_t clr_i,
  output reg_t flag_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_flag
    logic flag_q, flag_d, flag_upd;

    always_comb begin
      flag_upd = set_i[i] | clr_i[i];
      flag_d   = set_i[i] | (flag_q & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_upd) begin
        flag_q <= flag_d;
      end
    end

    assign flag_o[i] = flag_q;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          P3_W     = 8,
  parameter int          EXT_W    = 2,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'hC1,
  parameter logic [ADDR_W-1:0] ST_ADDR  = 8'hC2,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              usb_done_i,
  input  logic              tmr_uflow_i,
  input  logic [P3_W-1:0]   p3_pin_i,
  input  logic [P3_W-1:0]   p3_in_mode_i,
  input  logic [EXT_W-1:0]  ext_pin_i,
  input  logic [EXT_W-1:0]  ext_in_mode_i,
  output logic              irq_o
);
  logic [P3_W-1:0]  p3_fall;
  logic [EXT_W-1:0] ext_fall;
  reg_t set_vec, clr_vec, status_q;
  reg_t enable_q, enable_d;
  logic enable_we, clr_we;
  logic irq_q, irq_d;

  irq_pin_fall #(.WIDTH(P3_W)) u_p3_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (p3_pin_i),
    .mode_i (p3_in_mode_i),
    .fall_o (p3_fall)
  );

  irq_pin_fall #(.WIDTH(EXT_W)) u_ext_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin_i),
    .mode_i (ext_in_mode_i),
    .fall_o (ext_fall)
  );

  // Event vector in register bit order
  always_comb begin
    set_vec          = '0;
    set_vec[BIT_USB] = usb_done_i;
    set_vec[BIT_TMR] = tmr_uflow_i;
    set_vec[BIT_P3]  = |p3_fall;
    set_vec[BIT_X0]  = ext_fall[0];
    set_vec[BIT_X1]  = ext_fall[EXT_W-1];
  end

  // Bus write decode
  always_comb begin
    enable_we = bus_wr && (bus_addr == EN_ADDR);
    clr_we    = bus_wr && (bus_addr == CLR_ADDR);
    enable_d  = bus_wdata & FLAG_MASK;
    clr_vec   = clr_we ? (bus_wdata & FLAG_MASK) : '0;
  end

  irq_flag_bank u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (enable_we) begin
      enable_q <= enable_d;
    end
  end

  // Registered request
  always_comb irq_d = |(status_q & enable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // Read mux
  always_comb begin
    unique case (bus_addr)
      EN_ADDR: bus_rdata = enable_q;
      ST_ADDR: bus_rdata = status_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'hC3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input reg_t              bus_wdata,
  input reg_t              bus_rdata,
  input logic              usb_done_i,
  input reg_t              status_q,
  input reg_t              enable_q,
  input reg_t              set_vec,
  input logic              irq_o
);
  // Request trails masked flags by one cycle (R8)
  assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(status_q & enable_q))));

  // A fresh USB event always leaves its flag set (R10)
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    usb_done_i |=> status_q[BIT_USB]);

  // Cleared bits without a concurrent event go low (R9)
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CLR_ADDR) |=> ((status_q & $past(bus_wdata & ~set_vec)) == '0));

  // Without a clear write no flag falls (R3)
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == CLR_ADDR) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // Unused bit positions always read 0 (R2)
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~FLAG_MASK) == '0);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .usb_done_i (usb_done_i),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .set_vec    (set_vec),
  .irq_o      (irq_o)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  localparam logic [7:0] A_EN  = 8'hC1;
  localparam logic [7:0] A_ST  = 8'hC2;
  localparam logic [7:0] A_CLR = 8'hC3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       usb_done_i = 1'b0;
  logic       tmr_uflow_i = 1'b0;
  logic [7:0] p3_pin_i = 8'hFF;
  logic [7:0] p3_in_mode_i = 8'hFF;
  logic [1:0] ext_pin_i = 2'b11;
  logic [1:0] ext_in_mode_i = 2'b11;
  logic       irq_o;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .usb_done_i    (usb_done_i),
    .tmr_uflow_i   (tmr_uflow_i),
    .p3_pin_i      (p3_pin_i),
    .p3_in_mode_i  (p3_in_mode_i),
    .ext_pin_i     (ext_pin_i),
    .ext_in_mode_i (ext_in_mode_i),
    .irq_o         (irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks are entered just after a falling clock edge.
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check_reg("R1 enable after reset", A_EN, 8'h00);
    check_reg("R1 status after reset", A_ST, 8'h00);
    check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_enable_rw;
    bus_write(A_EN, 8'hFF);
    check_reg("R2 enable keeps bits 1-5", A_EN, 8'h3E);
    bus_write(A_EN, 8'h14);
    check_reg("R2 enable readback", A_EN, 8'h14);
    check_reg("R11 clear reads zero", A_CLR, 8'h00);
    check_reg("R11 unmapped reads zero", 8'hC0, 8'h00);
    bus_write(A_EN, 8'h00);
  endtask

  task automatic t_pulses;
    bus_write(A_EN, 8'h06);
    usb_done_i = 1'b1;
    @(negedge clk);
    usb_done_i = 1'b0;
    check_reg("R3 usb flag set at sampling edge", A_ST, 8'h02);
    check("R8 irq not yet high", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    check("R8 irq one cycle later", {7'd0, irq_o}, 8'h01);
    repeat (3) @(negedge clk);
    check_reg("R3 usb flag sticky", A_ST, 8'h02);
    tmr_uflow_i = 1'b1;
    @(negedge clk);
    tmr_uflow_i = 1'b0;
    check_reg("R3 timer flag set", A_ST, 8'h06);
    bus_write(A_CLR, 8'h02);
    check_reg("R9 clear one bit", A_ST, 8'h04);
    bus_write(A_CLR, 8'h00);
    check_reg("R9 zero write no effect", A_ST, 8'h04);
    bus_write(A_CLR, 8'h04);
    check_reg("R9 clear last bit", A_ST, 8'h00);
    check("R8 irq still high one cycle", {7'd0, irq_o}, 8'h01);
    @(negedge clk);
    check("R8 irq drops", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_masked;
    bus_write(A_EN, 8'h00);
    tmr_uflow_i = 1'b1;
    @(negedge clk);
    tmr_uflow_i = 1'b0;
    check_reg("R7 masked flag latches", A_ST, 8'h04);
    repeat (3) @(negedge clk);
    check("R7 masked irq low", {7'd0, irq_o}, 8'h00);
    bus_write(A_EN, 8'h04);
    check("R8 irq waits after enable", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    check("R8 irq after enable", {7'd0, irq_o}, 8'h01);
    bus_write(A_EN, 8'h00);
    bus_write(A_CLR, 8'h3E);
    check_reg("R9 clear all", A_ST, 8'h00);
  endtask

  // Drive a fall on one pin, check latency, clear, restore and check no rise event.
  task automatic pin_fall(input string req, input bit is_p3, input int idx,
                          input logic [7:0] exp);
    if (is_p3) p3_pin_i[idx] = 1'b0;
    else       ext_pin_i[idx] = 1'b0;
    repeat (2) @(negedge clk);
    check_reg({req, " not before sync"}, A_ST, 8'h00);
    @(negedge clk);
    check_reg({req, " flag after sync"}, A_ST, exp);
    bus_write(A_CLR, exp);
    if (is_p3) p3_pin_i[idx] = 1'b1;
    else       ext_pin_i[idx] = 1'b1;
    repeat (5) @(negedge clk);
    check_reg({req, " rising edge ignored"}, A_ST, 8'h00);
  endtask

  task automatic t_ext;
    pin_fall("R4 ext0", 1'b0, 0, 8'h10);
    pin_fall("R4 ext1", 1'b0, 1, 8'h20);
  endtask

  task automatic t_p3;
    for (int k = 0; k < 3; k++) begin
      int b;
      b = (k == 0) ? 0 : (k == 1) ? 3 : 7;
      pin_fall("R5 port3", 1'b1, b, 8'h08);
    end
  endtask

  task automatic t_mode;
    p3_in_mode_i  = 8'hFE;
    ext_in_mode_i = 2'b10;
    p3_pin_i[0]  = 1'b0;
    ext_pin_i[0] = 1'b0;
    repeat (5) @(negedge clk);
    check_reg("R6 output-mode pins ignored", A_ST, 8'h00);
    p3_pin_i[0]  = 1'b1;
    ext_pin_i[0] = 1'b1;
    repeat (5) @(negedge clk);
    p3_in_mode_i  = 8'hFF;
    ext_in_mode_i = 2'b11;
    @(negedge clk);
  endtask

  task automatic t_collide;
    usb_done_i = 1'b1;
    @(negedge clk);
    usb_done_i = 1'b0;
    usb_done_i = 1'b1;
    bus_write(A_CLR, 8'h02);
    usb_done_i = 1'b0;
    check_reg("R10 set beats clear", A_ST, 8'h02);
    bus_write(A_CLR, 8'h02);
    check_reg("R10 later clear works", A_ST, 8'h00);
  endtask

  task automatic t_readonly;
    bus_write(A_EN, 8'h0A);
    tmr_uflow_i = 1'b1;
    @(negedge clk);
    tmr_uflow_i = 1'b0;
    bus_write(A_ST, 8'hFF);
    check_reg("R11 status write ignored", A_ST, 8'h04);
    bus_write(8'hC4, 8'hFF);
    check_reg("R11 unmapped write keeps enable", A_EN, 8'h0A);
    check_reg("R11 unmapped write keeps status", A_ST, 8'h04);
    bus_write(A_CLR, 8'h04);
    bus_write(A_EN, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_rw();
    t_pulses();
    t_masked();
    t_ext();
    t_p3();
    t_mode();
    t_collide();
    t_readonly();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule